// File: doc/BRIEF.md
# Register Bridge to a Clock Synthesizer Reconfiguration Port

This block lets a processor reach the dynamic reconfiguration port of a clock synthesizer through four 32-bit registers on a simple memory-mapped bus. The bus has an address, a write strobe with write data, and a read strobe with registered read data. Two of the registers are plain controls: one releases the synthesizer's reset and enables it, and the other selects its reference clock.

The other two registers carry reconfiguration traffic. A write to the command register with its request bit set starts one read or write transaction on the port. A busy flag then blocks further requests until the port answers with ready. The status register holds that busy flag next to the data returned by the most recent port read. Software polls busy before each request, and after a read it polls again until busy drops, which tells it the data is valid.

Top module: `cfgport_bridge`

## Requirements
- R1: After reset every register reads zero, synth_rst_release, synth_enable, ref_sel, cfg_en, cfg_we, cfg_addr and cfg_di are all zero, and the busy flag is clear.
- R2: A write to byte address 0x40 stores wdata bit 0 into synth_rst_release and bit 1 into synth_enable. A read of 0x40 returns these two bits in positions 1:0 and zero in all other bits.
- R3: A write to 0x44 stores the low SEL_W bits into ref_sel. A read of 0x44 returns them zero-extended.
- R4: When busy is clear, a write to 0x70 with bit 29 set starts one transaction. From the next cycle busy (status bit 16) reads 1, and cfg_en is high for exactly one cycle. During that cycle cfg_we equals the inverse of bit 28 (1 = read), cfg_addr equals bits 22:16 and cfg_di equals bits 15:0. A read of 0x70 returns the accepted command with bit 28 at 28, the address at 22:16, the data at 15:0 and zeros elsewhere.
- R5: In the cycle after a clock edge that samples cfg_rdy high while busy is set, busy reads 0.
- R6: A read transaction copies cfg_do into status bits 15:0 at the completing edge. A write transaction leaves those bits unchanged.
- R7: While busy is set, a write to 0x70 is ignored, including a write in the cycle that samples cfg_rdy. It produces no cfg_en pulse, it leaves cfg_addr and cfg_di unchanged, and it leaves the 0x70 readback unchanged.
- R8: A write to 0x70 with bit 29 clear starts no transaction and leaves the 0x70 readback unchanged.
- R9: cfg_rdy asserted while busy is clear changes neither busy nor the status data.
- R10: bus_rdata is valid in the cycle after bus_ren is sampled. Unmapped addresses read zero. Writes to 0x74 and to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| synth_rst_release | output | 1 | Releases the synthesizer reset when high |
| synth_enable | output | 1 | Enables the synthesizer when high |
| ref_sel | output | SEL_W | Reference clock selection |
| cfg_en | output | 1 | One-cycle transaction strobe to the port |
| cfg_we | output | 1 | Port write enable, qualified by cfg_en |
| cfg_addr | output | DRP_AW | Port register address |
| cfg_di | output | DRP_DW | Port write data |
| cfg_do | input | DRP_DW | Port read data, valid with cfg_rdy |
| cfg_rdy | input | 1 | Port completion strobe |

## Verification
Two things can land on the same clock edge. First, the port's ready strobe can arrive in the same cycle as a new command write. Second, it can arrive in the same cycle as a status read. The bench holds the port answer under manual control and raises cfg_rdy in exactly the cycle in which it also drives each of these bus accesses. It then expects the new command to be dropped, because busy was still set at that edge. No cfg_en follows, and both the pins and the command readback keep the old transaction. It also expects the status read taken on that same edge to still show busy with the previous data, and a read one cycle later to show busy clear with the new data.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

   // register byte offsets
   localparam int unsigned OFS_RESET  = 32'h40;
   localparam int unsigned OFS_CLKSEL = 32'h44;
   localparam int unsigned OFS_CTL    = 32'h70;
   localparam int unsigned OFS_STAT   = 32'h74;

   // command word fields
   localparam int unsigned CTL_GO_BIT   = 29;
   localparam int unsigned CTL_RD_BIT   = 28;
   localparam int unsigned CTL_ADDR_LSB = 16;

   // status word fields
   localparam int unsigned STAT_BUSY_BIT = 16;

   localparam int unsigned BUS_DW = 32;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_RST,
      SEL_CLK,
      SEL_CTL,
      SEL_STAT
   } regsel_e;

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
   import cfgport_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output regsel_e           sel
);

   always_comb begin
      if (addr == ADDR_W'(OFS_RESET))       sel = SEL_RST;
      else if (addr == ADDR_W'(OFS_CLKSEL)) sel = SEL_CLK;
      else if (addr == ADDR_W'(OFS_CTL))    sel = SEL_CTL;
      else if (addr == ADDR_W'(OFS_STAT))   sel = SEL_STAT;
      else                                  sel = SEL_NONE;
   end

endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
   import cfgport_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned SEL_W     = 1,
   parameter int unsigned DRP_AW    = 7,
   parameter int unsigned DRP_DW    = 16,
   parameter bit          REG_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [BUS_DW-1:0] bus_wdata,
   input  logic              bus_ren,
   output logic [BUS_DW-1:0] bus_rdata,
   output logic              rel_o,
   output logic              ena_o,
   output logic [SEL_W-1:0]  ref_o,
   input  logic              busy,
   input  logic [DRP_DW-1:0] rd_data,
   output logic              start,
   output logic              start_rd,
   output logic [DRP_AW-1:0] start_addr,
   output logic [DRP_DW-1:0] start_data
);

   regsel_e            sel;
   logic               wr_rst, wr_clk, wr_ctl;
   logic               rel_q, ena_q;
   logic [SEL_W-1:0]   ref_q;
   logic               cmd_rd_q;
   logic [DRP_AW-1:0]  cmd_addr_q;
   logic [DRP_DW-1:0]  cmd_data_q;
   logic [BUS_DW-1:0]  rd_word;
   logic               wdata_unused;

   cfgport_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   assign wr_rst = bus_wen && (sel == SEL_RST);
   assign wr_clk = bus_wen && (sel == SEL_CLK);
   assign wr_ctl = bus_wen && (sel == SEL_CTL);

   assign start      = wr_ctl && bus_wdata[CTL_GO_BIT] && !busy;
   assign start_rd   = bus_wdata[CTL_RD_BIT];
   assign start_addr = bus_wdata[CTL_ADDR_LSB +: DRP_AW];
   assign start_data = bus_wdata[DRP_DW-1:0];

   assign wdata_unused = ^bus_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rel_q      <= 1'b0;
         ena_q      <= 1'b0;
         ref_q      <= '0;
         cmd_rd_q   <= 1'b0;
         cmd_addr_q <= '0;
         cmd_data_q <= '0;
      end else begin
         if (wr_rst) begin
            rel_q <= bus_wdata[0];
            ena_q <= bus_wdata[1];
         end
         if (wr_clk) begin
            ref_q <= bus_wdata[SEL_W-1:0];
         end
         if (start) begin
            cmd_rd_q   <= start_rd;
            cmd_addr_q <= start_addr;
            cmd_data_q <= start_data;
         end
      end
   end

   assign rel_o = rel_q;
   assign ena_o = ena_q;
   assign ref_o = ref_q;

   always_comb begin
      rd_word = '0;
      case (sel)
         SEL_RST: begin
            rd_word[0] = rel_q;
            rd_word[1] = ena_q;
         end
         SEL_CLK: begin
            rd_word[SEL_W-1:0] = ref_q;
         end
         SEL_CTL: begin
            rd_word[CTL_RD_BIT]                = cmd_rd_q;
            rd_word[CTL_ADDR_LSB +: DRP_AW]    = cmd_addr_q;
            rd_word[DRP_DW-1:0]                = cmd_data_q;
         end
         SEL_STAT: begin
            rd_word[STAT_BUSY_BIT] = busy;
            rd_word[DRP_DW-1:0]    = rd_data;
         end
         default: rd_word = '0;
      endcase
   end

   generate
      if (REG_RDATA) begin : g_rd_flop
         logic [BUS_DW-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rdata_q <= '0;
            end else if (bus_ren) begin
               rdata_q <= rd_word;
            end
         end
         assign bus_rdata = rdata_q;
      end else begin : g_rd_comb
         assign bus_rdata = bus_ren ? rd_word : '0;
      end
   endgenerate

endmodule

// File: rtl/cfgport_xact.sv
module cfgport_xact #(
   parameter int unsigned DRP_AW = 7,
   parameter int unsigned DRP_DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_rd,
   input  logic [DRP_AW-1:0] start_addr,
   input  logic [DRP_DW-1:0] start_data,
   input  logic [DRP_DW-1:0] cfg_do,
   input  logic              cfg_rdy,
   output logic              busy,
   output logic              rd_pend,
   output logic [DRP_DW-1:0] rd_data,
   output logic              cfg_en,
   output logic              cfg_we,
   output logic [DRP_AW-1:0] cfg_addr,
   output logic [DRP_DW-1:0] cfg_di
);

   logic              busy_q, pend_q, en_q, we_q;
   logic [DRP_AW-1:0] addr_q;
   logic [DRP_DW-1:0] di_q, rdat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pend_q <= 1'b0;
         en_q   <= 1'b0;
         we_q   <= 1'b0;
         addr_q <= '0;
         di_q   <= '0;
         rdat_q <= '0;
      end else begin
         en_q <= start;
         if (start) begin
            busy_q <= 1'b1;
            pend_q <= start_rd;
            we_q   <= !start_rd;
            addr_q <= start_addr;
            di_q   <= start_data;
         end else if (busy_q && cfg_rdy) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
            if (pend_q) begin
               rdat_q <= cfg_do;
            end
         end
      end
   end

   assign busy     = busy_q;
   assign rd_pend  = pend_q;
   assign rd_data  = rdat_q;
   assign cfg_en   = en_q;
   assign cfg_we   = we_q;
   assign cfg_addr = addr_q;
   assign cfg_di   = di_q;

endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge
   import cfgport_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned SEL_W     = 1,
   parameter int unsigned DRP_AW    = 7,
   parameter int unsigned DRP_DW    = 16,
   parameter bit          REG_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_ren,
   output logic [31:0]       bus_rdata,
   output logic              synth_rst_release,
   output logic              synth_enable,
   output logic [SEL_W-1:0]  ref_sel,
   output logic              cfg_en,
   output logic              cfg_we,
   output logic [DRP_AW-1:0] cfg_addr,
   output logic [DRP_DW-1:0] cfg_di,
   input  logic [DRP_DW-1:0] cfg_do,
   input  logic              cfg_rdy
);

   generate
      if (ADDR_W < 7 || ADDR_W > 32) begin : g_bad_addr
         $error("cfgport_bridge: ADDR_W must cover offset 0x74 and fit 32 bits");
      end
      if (DRP_AW < 1 || DRP_AW > 12) begin : g_bad_aw
         $error("cfgport_bridge: DRP_AW must lie in 1..12");
      end
      if (DRP_DW < 1 || DRP_DW > 16) begin : g_bad_dw
         $error("cfgport_bridge: DRP_DW must lie in 1..16");
      end
      if (SEL_W < 1 || SEL_W > 16) begin : g_bad_sel
         $error("cfgport_bridge: SEL_W must lie in 1..16");
      end
   endgenerate

   logic              busy_w, pend_w, start_w, start_rd_w;
   logic [DRP_AW-1:0] start_addr_w;
   logic [DRP_DW-1:0] start_data_w, rd_data_w;

   cfgport_regs #(
      .ADDR_W    (ADDR_W),
      .SEL_W     (SEL_W),
      .DRP_AW    (DRP_AW),
      .DRP_DW    (DRP_DW),
      .REG_RDATA (REG_RDATA)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wen    (bus_wen),
      .bus_wdata  (bus_wdata),
      .bus_ren    (bus_ren),
      .bus_rdata  (bus_rdata),
      .rel_o      (synth_rst_release),
      .ena_o      (synth_enable),
      .ref_o      (ref_sel),
      .busy       (busy_w),
      .rd_data    (rd_data_w),
      .start      (start_w),
      .start_rd   (start_rd_w),
      .start_addr (start_addr_w),
      .start_data (start_data_w)
   );

   cfgport_xact #(
      .DRP_AW (DRP_AW),
      .DRP_DW (DRP_DW)
   ) u_xact (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_w),
      .start_rd   (start_rd_w),
      .start_addr (start_addr_w),
      .start_data (start_data_w),
      .cfg_do     (cfg_do),
      .cfg_rdy    (cfg_rdy),
      .busy       (busy_w),
      .rd_pend    (pend_w),
      .rd_data    (rd_data_w),
      .cfg_en     (cfg_en),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_di     (cfg_di)
   );

endmodule

// File: rtl/cfgport_bridge_chk.sv
module cfgport_bridge_chk #(
   parameter int unsigned DRP_AW = 7,
   parameter int unsigned DRP_DW = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_w,
   input logic              busy_w,
   input logic              pend_w,
   input logic [DRP_DW-1:0] rd_data_w,
   input logic              cfg_en,
   input logic [DRP_AW-1:0] cfg_addr,
   input logic [DRP_DW-1:0] cfg_di,
   input logic [DRP_DW-1:0] cfg_do,
   input logic              cfg_rdy
);

   // R4
   en_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |=> !cfg_en);

   // R4
   start_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_w |=> (cfg_en && busy_w));

   // R5
   busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_w && cfg_rdy) |=> !busy_w);

   // R7
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_w && !cfg_rdy) |=> (busy_w && !cfg_en && $stable(cfg_addr) && $stable(cfg_di)));

   // R6
   rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_w && cfg_rdy && pend_w) |=> (rd_data_w == $past(cfg_do)));

   // R6
   wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_w && cfg_rdy && !pend_w) |=> $stable(rd_data_w));

   // R9
   idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_w && !start_w) |=> (!busy_w && $stable(rd_data_w)));

endmodule

bind cfgport_bridge cfgport_bridge_chk #(
   .DRP_AW (DRP_AW),
   .DRP_DW (DRP_DW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_w   (start_w),
   .busy_w    (busy_w),
   .pend_w    (pend_w),
   .rd_data_w (rd_data_w),
   .cfg_en    (cfg_en),
   .cfg_addr  (cfg_addr),
   .cfg_di    (cfg_di),
   .cfg_do    (cfg_do),
   .cfg_rdy   (cfg_rdy)
);

// File: tb/cfgport_bridge_tb.sv
`timescale 1ns/1ps
module cfgport_bridge_tb;

   localparam int ADDR_W = 8;
   localparam int SEL_W  = 1;
   localparam int DRP_AW = 7;
   localparam int DRP_DW = 16;
   localparam int LAT    = 3;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [ADDR_W-1:0] bus_addr;
   logic              bus_wen, bus_ren;
   logic [31:0]       bus_wdata, bus_rdata;
   logic              synth_rst_release, synth_enable;
   logic [SEL_W-1:0]  ref_sel;
   logic              cfg_en, cfg_we, cfg_rdy;
   logic [DRP_AW-1:0] cfg_addr;
   logic [DRP_DW-1:0] cfg_di, cfg_do;

   always #10 clk = ~clk;

   cfgport_bridge #(
      .ADDR_W (ADDR_W), .SEL_W (SEL_W), .DRP_AW (DRP_AW), .DRP_DW (DRP_DW)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wen (bus_wen),
      .bus_wdata (bus_wdata), .bus_ren (bus_ren), .bus_rdata (bus_rdata),
      .synth_rst_release (synth_rst_release), .synth_enable (synth_enable),
      .ref_sel (ref_sel), .cfg_en (cfg_en), .cfg_we (cfg_we),
      .cfg_addr (cfg_addr), .cfg_di (cfg_di), .cfg_do (cfg_do),
      .cfg_rdy (cfg_rdy)
   );

   int n_cmp  = 0;
   int n_bad  = 0;
   int en_cnt = 0;
   bit done   = 1'b0;

   // behavioural port responder
   logic              auto_mode = 1'b1;
   logic              man_rdy;
   logic [DRP_DW-1:0] man_do;
   logic              auto_rdy = 1'b0;
   logic [DRP_DW-1:0] auto_do = '0;
   logic [DRP_DW-1:0] mem [128];
   int                lat_cnt = 0;
   logic              cap_rd = 1'b0;
   logic [DRP_AW-1:0] cap_addr = '0;

   assign cfg_rdy = auto_mode ? auto_rdy : man_rdy;
   assign cfg_do  = auto_mode ? auto_do  : man_do;

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = '0;
   end

   always @(posedge clk) begin
      auto_rdy <= 1'b0;
      if (rst_n && cfg_en) begin
         en_cnt   <= en_cnt + 1;
         cap_rd   <= !cfg_we;
         cap_addr <= cfg_addr;
         if (cfg_we) mem[cfg_addr] <= cfg_di;
         lat_cnt  <= LAT;
      end else if (lat_cnt != 0) begin
         lat_cnt <= lat_cnt - 1;
         if (lat_cnt == 1) begin
            auto_rdy <= 1'b1;
            auto_do  <= cap_rd ? mem[cap_addr] : 16'h0000;
         end
      end
   end

   // scoreboard
   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        ren_seen = 1'b0;

   always @(posedge clk) ren_seen <= bus_ren;

   always @(negedge clk) begin
      if (ren_seen) begin
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL scoreboard: read result with no expected entry, actual %h expected none", bus_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (bus_rdata !== e) begin
               n_bad++;
               $display("FAIL %s: bus_rdata actual %h expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string t);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", t, act, exp);
      end
   endtask

   // one bus cycle, entered and left at a falling edge
   task automatic cyc(input logic wen, input logic ren, input int addr,
                      input logic [31:0] wd, input logic rdy, input logic [15:0] dout,
                      input logic [31:0] exp, input string t);
      bus_wen   = wen;
      bus_ren   = ren;
      bus_addr  = ADDR_W'(addr);
      bus_wdata = wd;
      man_rdy   = rdy;
      man_do    = dout;
      if (ren) begin
         exp_q.push_back(exp);
         tag_q.push_back(t);
      end
      @(negedge clk);
      bus_wen = 1'b0;
      bus_ren = 1'b0;
      man_rdy = 1'b0;
   endtask

   task automatic wr(input int addr, input logic [31:0] wd);
      cyc(1'b1, 1'b0, addr, wd, 1'b0, 16'h0, 32'h0, "");
   endtask

   task automatic rd(input int addr, input logic [31:0] exp, input string t);
      cyc(1'b0, 1'b1, addr, 32'h0, 1'b0, 16'h0, exp, t);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int base;
      rst_n = 1'b0; bus_wen = 1'b0; bus_ren = 1'b0; bus_addr = '0;
      bus_wdata = '0; man_rdy = 1'b0; man_do = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check({28'h0, synth_rst_release, synth_enable, ref_sel, cfg_en},
            32'h0, "R1 control pins");
      check({cfg_we, cfg_addr, cfg_di}, 32'h0, "R1 port pins");
      rd('h40, 32'h0, "R1 reset reg");
      rd('h44, 32'h0, "R1 select reg");
      rd('h70, 32'h0, "R1 command reg");
      rd('h74, 32'h0, "R1 status reg");

      // R2 reset/enable register
      wr('h40, 32'hFFFF_FFFF);
      check({30'h0, synth_enable, synth_rst_release}, 32'h3, "R2 both set");
      rd('h40, 32'h3, "R2 readback 3");
      wr('h40, 32'h0000_0001);
      check({30'h0, synth_enable, synth_rst_release}, 32'h1, "R2 release only");
      rd('h40, 32'h1, "R2 readback 1");

      // R3 select register
      wr('h44, 32'h0000_0003);
      check(32'(ref_sel), 32'h1, "R3 ref_sel");
      rd('h44, 32'h1, "R3 readback");
      wr('h44, 32'h0);
      check(32'(ref_sel), 32'h0, "R3 ref_sel cleared");

      // R4 port write transaction
      base = en_cnt;
      wr('h70, 32'h2015_BEEF);
      check({29'h0, cfg_en, cfg_we, 1'b0}, 32'h6, "R4 strobe and write enable");
      check({9'h0, cfg_addr, cfg_di}, 32'h0015_BEEF, "R4 address and data");
      rd('h74, 32'h0001_0000, "R4 busy after start");
      check(32'(cfg_en), 32'h0, "R4 strobe one cycle");
      idle(8);
      check(32'(en_cnt - base), 32'h1, "R4 single strobe");
      rd('h74, 32'h0, "R5 busy clear after write");
      rd('h70, 32'h0015_BEEF, "R4 command readback");

      // R6 port read transaction
      wr('h70, 32'h3015_1234);
      check({31'h0, cfg_we}, 32'h0, "R4 read has write enable low");
      idle(8);
      rd('h74, 32'h0000_BEEF, "R6 read data captured");
      rd('h70, 32'h1015_1234, "R4 read command readback");
      wr('h70, 32'h2020_5555);
      idle(8);
      rd('h74, 32'h0000_BEEF, "R6 write leaves data");

      // R7 commands while busy, manual responder
      auto_mode = 1'b0;
      base = en_cnt;
      wr('h70, 32'h3033_0000);
      wr('h70, 32'h2044_AAAA);
      check({9'h0, cfg_addr, cfg_di}, 32'h0033_0000, "R7 pins kept while busy");
      rd('h70, 32'h1033_0000, "R7 readback kept while busy");
      // collision: ready and new command in one cycle
      cyc(1'b1, 1'b0, 'h70, 32'h2001_1111, 1'b1, 16'h7E57, 32'h0, "");
      idle(2);
      check(32'(en_cnt - base), 32'h1, "R7 no strobe for dropped commands");
      check(32'(cfg_addr), 32'h33, "R7 address after collision");
      rd('h74, 32'h0000_7E57, "R5 busy clear with read data");
      rd('h70, 32'h1033_0000, "R7 readback after collision");

      // collision: ready and status read in one cycle
      wr('h70, 32'h3002_0000);
      cyc(1'b0, 1'b1, 'h74, 32'h0, 1'b1, 16'h0BAD, 32'h0001_7E57, "R5 status on completing edge");
      rd('h74, 32'h0000_0BAD, "R6 data one cycle later");

      // R8 command without request bit
      base = en_cnt;
      wr('h70, 32'h1050_9999);
      idle(2);
      check(32'(en_cnt - base), 32'h0, "R8 no strobe");
      rd('h70, 32'h1002_0000, "R8 readback unchanged");
      rd('h74, 32'h0000_0BAD, "R8 still idle");

      // R9 ready while idle
      cyc(1'b0, 1'b0, 0, 32'h0, 1'b1, 16'hFFFF, 32'h0, "");
      rd('h74, 32'h0000_0BAD, "R9 stray ready ignored");

      // R10 unmapped and read-only addresses
      rd('h00, 32'h0, "R10 unmapped 0x00");
      rd('h7C, 32'h0, "R10 unmapped 0x7C");
      wr('h74, 32'hFFFF_FFFF);
      rd('h74, 32'h0000_0BAD, "R10 status write ignored");
      wr('h48, 32'hFFFF_FFFF);
      rd('h44, 32'h0, "R10 unmapped write ignored");
      rd('h40, 32'h1, "R10 reset reg kept");

      idle(3);
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: %0d reads never returned, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule